// File: doc/BRIEF.md
# GPIO Bank with Half-Word Masked Output Writes

This block is one general-purpose I/O bank of up to 32 pins behind a simple single-cycle register bus. Software reaches the pins through five registers. Two write-only data ports each update one 16-pin half of the bank. A read-only register returns the synchronised pin levels. Two read/write registers, the direction register and the drive-enable register, decide which pins are driven.

A half-bank data write carries a per-bit keep mask in its upper 16 bits and new values in its lower 16 bits. Only the output bits whose keep bit is clear take the new value. Software can therefore change any subset of outputs in one bus write, with no read-modify-write sequence. A pin is driven only when both its direction bit and its drive-enable bit are 1. Pin inputs pass through a two-flop synchroniser before they become readable.

The bank index parameter places the register offsets. Banks with fewer than 32 pins are supported. On such a bank the missing bits read as zero and writes to them have no effect.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, output data, direction and drive-enable are all zero: `pin_out` and `pin_oe` are 0, and the direction and drive-enable registers read 0.
- R2: A write to the lower data port at offset 0x000 + 8*BANK_IDX updates output bit i (0 to 15). Each such bit becomes wdata[i] when wdata[16+i] is 0 and keeps its value when wdata[16+i] is 1. Output bits 16 to 31 do not change.
- R3: A write to the upper data port at offset 0x004 + 8*BANK_IDX updates output bit 16+i. Each such bit becomes wdata[i] when wdata[16+i] is 0 and keeps its value when wdata[16+i] is 1. Output bits 0 to 15 do not change.
- R4: The direction register at offset 0x204 + 0x40*BANK_IDX is written whole and reads back its stored value (1 = output, 0 = input).
- R5: The drive-enable register at offset 0x208 + 0x40*BANK_IDX is written whole and reads back its stored value.
- R6: `pin_oe[i]` is 1 exactly when direction bit i and drive-enable bit i are both 1.
- R7: A read at offset 0x060 + 4*BANK_IDX returns the value `pin_in` had two rising clock edges earlier, one bit per pin. Writes to this offset change nothing.
- R8: Bits at or above NUM_PINS read as 0 from every register, and writes to them have no effect.
- R9: Reads of the data ports and of any unmapped offset return 0. This includes offsets that belong to other bank indices. Writes to unmapped offsets change no register.
- R10: Register writes take effect on the clock edge where `bus_wr` is sampled high. Read data is combinational on `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output data value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |

## Verification
The bench builds the bank with NUM_PINS = 22 and BANK_IDX = 1. With 22 pins the upper half port holds only six real pins, so writes and keep-mask bits that land on bits 22 to 31 exercise the unimplemented-bit rule. With a bank index of 1 every offset is shifted, so writes aimed at the bank-0 offsets become stray accesses that must leave all state untouched. A behavioural model tracks the output, direction, enable and synchroniser state, and every clock it is compared against all three outputs. Directed phases are followed by a random mix of accesses and a mid-run reset.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;

    // Register offsets and per-bank strides
    localparam int unsigned OFS_DATA_LO   = 'h000;
    localparam int unsigned OFS_DATA_HI   = 'h004;
    localparam int unsigned STRIDE_DATA   = 8;
    localparam int unsigned OFS_PIN_STATE = 'h060;
    localparam int unsigned STRIDE_STATE  = 4;
    localparam int unsigned OFS_DIR       = 'h204;
    localparam int unsigned OFS_DRIVE_EN  = 'h208;
    localparam int unsigned STRIDE_CFG    = 'h40;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DATA_LO,
        REG_DATA_HI,
        REG_PIN_STATE,
        REG_DIR,
        REG_DRIVE_EN
    } gpio_reg_e;

    // Architectural state of one bank, full word wide; unimplemented bits stay 0
    typedef struct packed {
        logic [WORD_W-1:0] drive_val;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] drive_en;
    } gpio_cfg_t;

    // Keep-mask merge: keep bit 1 holds the current bit, 0 takes the new one
    function automatic logic [HALF_W-1:0] masked_merge(
        input logic [HALF_W-1:0] cur,
        input logic [WORD_W-1:0] word
    );
        logic [HALF_W-1:0] keep;
        keep = word[WORD_W-1:HALF_W];
        return (cur & keep) | (word[HALF_W-1:0] & ~keep);
    endfunction

    function automatic logic [WORD_W-1:0] impl_mask(input int unsigned pins);
        logic [WORD_W-1:0] m;
        for (int unsigned b = 0; b < WORD_W; b++) m[b] = (b < pins);
        return m;
    endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned BANK_IDX = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_reg_e         sel
);
    localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(OFS_DATA_LO   + STRIDE_DATA  * BANK_IDX);
    localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OFS_DATA_HI   + STRIDE_DATA  * BANK_IDX);
    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(OFS_PIN_STATE + STRIDE_STATE * BANK_IDX);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR       + STRIDE_CFG   * BANK_IDX);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_DRIVE_EN  + STRIDE_CFG   * BANK_IDX);

    always_comb begin
        sel = REG_NONE;
        if      (addr == A_LO)    sel = REG_DATA_LO;
        else if (addr == A_HI)    sel = REG_DATA_HI;
        else if (addr == A_STATE) sel = REG_PIN_STATE;
        else if (addr == A_DIR)   sel = REG_DIR;
        else if (addr == A_EN)    sel = REG_DRIVE_EN;
    end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  gpio_reg_e         sel,
    input  logic [WORD_W-1:0] wdata,
    output gpio_cfg_t         cfg
);
    localparam logic [WORD_W-1:0] IMPL = impl_mask(NUM_PINS);

    gpio_cfg_t cfg_nxt;

    always_comb begin
        cfg_nxt = cfg;
        if (wr_en) begin
            unique case (sel)
                REG_DATA_LO:  cfg_nxt.drive_val = {cfg.drive_val[WORD_W-1:HALF_W],
                                                   masked_merge(cfg.drive_val[HALF_W-1:0], wdata)};
                REG_DATA_HI:  cfg_nxt.drive_val = {masked_merge(cfg.drive_val[WORD_W-1:HALF_W], wdata),
                                                   cfg.drive_val[HALF_W-1:0]};
                REG_DIR:      cfg_nxt.dir       = wdata;
                REG_DRIVE_EN: cfg_nxt.drive_en  = wdata;
                default: ;
            endcase
        end
        cfg_nxt.drive_val &= IMPL;
        cfg_nxt.dir       &= IMPL;
        cfg_nxt.drive_en  &= IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else     cfg <= cfg_nxt;
    end

    AST_LO_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DATA_LO) |=>
        (((cfg.drive_val ^ $past(cfg.drive_val)) & {16'h0, $past(wdata[31:16])}) == '0)); // R2
    AST_LO_SPARES_HI: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DATA_LO) |=> $stable(cfg.drive_val[31:16])); // R2
    AST_HI_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DATA_HI) |=>
        (((cfg.drive_val ^ $past(cfg.drive_val)) & {$past(wdata[31:16]), 16'h0}) == '0)); // R3
    AST_HI_SPARES_LO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DATA_HI) |=> $stable(cfg.drive_val[15:0])); // R3
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned BANK_IDX = 0,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    localparam logic [WORD_W-1:0] IMPL = impl_mask(NUM_PINS);

    gpio_reg_e           sel;
    gpio_cfg_t           cfg;
    logic [NUM_PINS-1:0] pin_sync;

    gpio_bank_decode #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    assign pin_out = cfg.drive_val[NUM_PINS-1:0];
    assign pin_oe  = cfg.dir[NUM_PINS-1:0] & cfg.drive_en[NUM_PINS-1:0];

    always_comb begin
        unique case (sel)
            REG_PIN_STATE: bus_rdata = WORD_W'(pin_sync);
            REG_DIR:       bus_rdata = cfg.dir;
            REG_DRIVE_EN:  bus_rdata = cfg.drive_en;
            default:       bus_rdata = '0;
        endcase
    end

    AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~IMPL) == '0); // R8
    AST_OE_RISE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~$past(pin_oe)) != '0) |-> $past(bus_wr)); // R6
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R10
    AST_STRAY_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_NONE) |=> ($stable(pin_out) && $stable(pin_oe))); // R9
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    localparam int NP = 22;
    localparam int AW = 12;
    localparam logic [31:0] IMPL = 32'h003F_FFFF;
    // bank index 1 offsets
    localparam logic [AW-1:0] A_LO = 12'h008, A_HI = 12'h00C, A_ST = 12'h064,
                              A_DIR = 12'h244, A_EN = 12'h248;

    logic          clk = 0;
    logic          rst = 1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    int n_tests = 0, n_fail = 0;

    gpio_bank_ctrl #(.NUM_PINS(NP), .BANK_IDX(1), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_out = 0, m_dir = 0, m_en = 0, m_s1 = 0, m_s2 = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_dir = 0; m_en = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = {10'b0, pin_in};
            if (bus_wr) begin
                if (bus_addr == A_LO) begin
                    for (int i = 0; i < 16; i++)
                        if (!bus_wdata[16+i]) m_out[i] = bus_wdata[i];
                end else if (bus_addr == A_HI) begin
                    for (int i = 0; i < 16; i++)
                        if (!bus_wdata[16+i] && (16 + i) < NP) m_out[16+i] = bus_wdata[i];
                end else if (bus_addr == A_DIR) begin
                    m_dir = bus_wdata & IMPL;
                end else if (bus_addr == A_EN) begin
                    m_en = bus_wdata & IMPL;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] exp_rd;
        string tag;
        check("R2 R3 R8 pin_out", {10'b0, pin_out}, m_out);
        check("R6 pin_oe", {10'b0, pin_oe}, m_dir & m_en);
        if (bus_addr == A_ST)       begin exp_rd = m_s2;  tag = "R7 state read"; end
        else if (bus_addr == A_DIR) begin exp_rd = m_dir; tag = "R4 R8 dir read"; end
        else if (bus_addr == A_EN)  begin exp_rd = m_en;  tag = "R5 R8 en read"; end
        else                        begin exp_rd = 0;     tag = "R9 zero read"; end
        check(tag, bus_rdata, exp_rd);
    endtask

    // compare current state, then drive one bus cycle (R10)
    task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [31:0] d,
                       input logic [NP-1:0] p);
        @(negedge clk);
        compare_all();
        bus_addr = a; bus_wr = w; bus_wdata = d; pin_in = p;
    endtask

    bit done = 0;
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pick [10];
        pick = '{A_LO, A_HI, A_ST, A_DIR, A_EN, 12'h000, 12'h004, 12'h204, 12'h060, 12'h208};
        for (int k = 0; k < 3; k++) cyc(A_DIR, 1'b1, 32'hFFFF_FFFF, '0);
        cyc(A_DIR, 1'b0, 0, '0);
        rst = 0;
        // R1: registers and pins clear after reset
        cyc(A_EN, 1'b0, 0, '0);
        check("R1 pin_out", {10'b0, pin_out}, 0);
        check("R1 pin_oe", {10'b0, pin_oe}, 0);
        check("R1 en read", bus_rdata, 0);
        cyc(A_DIR, 1'b0, 0, '0);
        check("R1 dir read", bus_rdata, 0);
        // R2: lower half, all bits writable then keep mask
        cyc(A_LO, 1'b1, 32'h0000_A5C3, '0);
        cyc(A_LO, 1'b1, 32'hFF00_0000, '0);
        cyc(A_LO, 1'b1, 32'h00FF_FFFF, '0);
        cyc(A_LO, 1'b1, 32'h5555_0000, '0);
        // R3: upper half, includes unimplemented bits (R8)
        cyc(A_HI, 1'b1, 32'h0000_FFFF, '0);
        cyc(A_HI, 1'b1, 32'hFFF5_0000, '0);
        cyc(A_HI, 1'b1, 32'h0000_0000, '0);
        // R4 R5 R6: direction and enable combinations
        cyc(A_DIR, 1'b1, 32'hFFFF_0F0F, '0);
        cyc(A_EN, 1'b1, 32'hFFFF_00FF, '0);
        cyc(A_DIR, 1'b0, 0, '0);
        cyc(A_EN, 1'b0, 0, '0);
        // R9: bank-0 offsets and state register writes must change nothing
        cyc(12'h000, 1'b1, 32'h0000_FFFF, '0);
        cyc(12'h004, 1'b1, 32'h0000_FFFF, '0);
        cyc(12'h204, 1'b1, 32'h0000_0000, '0);
        cyc(12'h208, 1'b1, 32'h0000_0000, '0);
        cyc(A_ST, 1'b1, 32'hFFFF_FFFF, '0);
        cyc(A_LO, 1'b0, 0, '0);
        cyc(A_DIR, 1'b0, 0, '0);
        // R7: synchroniser latency with walking pins
        for (int k = 0; k < NP + 4; k++) cyc(A_ST, 1'b0, 0, NP'(1) << (k % NP));
        cyc(A_ST, 1'b0, 0, '1);
        cyc(A_ST, 1'b0, 0, '0);
        cyc(A_ST, 1'b0, 0, '0);
        cyc(A_ST, 1'b0, 0, '0);
        // random mix
        for (int k = 0; k < 400; k++)
            cyc(pick[$urandom_range(9)], 1'($urandom), $urandom, NP'($urandom));
        // R1: mid-run reset
        rst = 1;
        cyc(A_EN, 1'b0, 0, '1);
        cyc(A_EN, 1'b0, 0, '1);
        rst = 0;
        for (int k = 0; k < 200; k++)
            cyc(pick[$urandom_range(9)], 1'($urandom), $urandom, NP'($urandom));
        cyc(A_ST, 1'b0, 0, '0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule